// File: doc/BRIEF.md
# Serial-Load Switch Control Register

This block is the logic core that steers a bank of six single-pole double-throw switches. Each channel has one select bit: 1 routes the channel's common terminal to its alternate throw, and 0 routes it to the default throw. Select data arrives one bit at a time on `ser_in`. It is clocked into a six-stage shift register on the rising edge of the shift clock, which runs at up to 5 MHz.

A bank of level-sensitive channel latches sits between the shift register and the `sel` outputs. While `latch_en` is low the latches are transparent and follow the shift register. While it is high they hold whatever they last captured. A high level on `clear` forces every select bit to the default throw at once. It overrides both data and `latch_en`, and it leaves the shift register untouched. The last shift stage drives `ser_out`, so several devices can share one data stream in a chain.

Top module: `swsel_ctrl`

## Requirements
- R1: With `rst` high at a rising `clk` edge, every shift stage and `ser_out` become 0 on that edge.
- R2: On each rising `clk` edge with `rst` low, `ser_in` enters stage 0 and every stage k takes the former value of stage k-1.
- R3: After six shifts, the first bit shifted in controls `sel[5]` and the last bit shifted in controls `sel[0]`.
- R4: While `latch_en` is low and `clear` is low, `sel` equals the shift register contents (bit i = stage i; 1 = alternate throw, 0 = default throw).
- R5: While `latch_en` is high and `clear` is low, `sel` keeps its value even as the shift register changes.
- R6: While `clear` is high, `sel` is all zeros whatever `latch_en` and `ser_in` are.
- R7: `clear` does not change the shift register: when `clear` falls with `latch_en` low, `sel` shows the contents that were shifted in.
- R8: `ser_out` equals shift stage 5, so it changes only on a rising `clk` edge and carries the bit shifted in six edges earlier.
- R9: With `ser_out` of one device wired to `ser_in` of a second on the same clock, after twelve shifts the second device holds the first six bits and the first device holds the last six.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; data moves on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the shift register |
| ser_in | input | 1 | Serial select data into stage 0 |
| latch_en | input | 1 | High holds the channel latches; low makes them transparent |
| clear | input | 1 | High forces all select bits to the default throw |
| sel | output | 6 | Per-channel select, 1 = alternate throw |
| ser_out | output | 1 | Shift stage 5, for chaining devices |

## Verification
The bench targets the bit order of a full load. A design with the shift reversed would drive channel 0 from the first bit, and the mirrored pattern would appear on `sel`. It toggles `latch_en` while data keeps shifting. A latch that captured on an edge, or stayed open while `latch_en` was high, would let `sel` change mid-load. It raises and drops `clear` with `latch_en` both high and low. A clear that also wiped the shift register would show all zeros once released, and a clear that lost priority to `latch_en` would leave stale selects. A chained pair checks that `ser_out` presents stage 5 on the clock edge. An off-by-one tap would shift the second device's pattern by one channel.

// File: rtl/swsel_pkg.sv
package swsel_pkg;

    localparam int NCH_DEF = 6;

    // Latch bank behaviour selected by the control pins.
    typedef enum logic [1:0] {
        LM_CLEAR  = 2'd0,
        LM_FOLLOW = 2'd1,
        LM_HOLD   = 2'd2
    } latch_mode_e;

    // Clear wins over latch enable; latch enable high means hold.
    function automatic latch_mode_e mode_of(input logic le, input logic clr);
        if (clr)
            return LM_CLEAR;
        else if (le)
            return LM_HOLD;
        else
            return LM_FOLLOW;
    endfunction

endpackage

// File: rtl/swsel_shift.sv
module swsel_shift #(
    parameter int NCH = swsel_pkg::NCH_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           din,
    output logic [NCH-1:0] stage,
    output logic           dout
);
    localparam int LAST = NCH - 1;

    logic [NCH-1:0] stage_q;

    // Bit entering now moves toward the top stage one place per edge.
    always_ff @(posedge clk) begin
        if (rst)
            stage_q <= '0;
        else
            stage_q <= {stage_q[LAST-1:0], din};
    end

    assign stage = stage_q;
    assign dout  = stage_q[LAST];

endmodule

// File: rtl/swsel_latch.sv
module swsel_latch #(
    parameter int NCH = swsel_pkg::NCH_DEF
) (
    input  logic                   le,
    input  logic                   clr,
    input  logic [NCH-1:0]         d,
    output logic [NCH-1:0]         q
);
    import swsel_pkg::*;

    latch_mode_e mode;

    always_comb mode = mode_of(le, clr);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic q_bit;

        // Level-sensitive cell with a dominant clear.
        always_latch begin
            if (mode == LM_CLEAR)
                q_bit = 1'b0;
            else if (mode == LM_FOLLOW)
                q_bit = d[i];
        end

        assign q[i] = q_bit;
    end

endmodule

// File: rtl/swsel_ctrl.sv
module swsel_ctrl #(
    parameter int NCH = swsel_pkg::NCH_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ser_in,
    input  logic           latch_en,
    input  logic           clear,
    output logic [NCH-1:0] sel,
    output logic           ser_out
);
    logic [NCH-1:0] stage_q;

    swsel_shift #(.NCH(NCH)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .din   (ser_in),
        .stage (stage_q),
        .dout  (ser_out)
    );

    swsel_latch #(.NCH(NCH)) u_latch (
        .le  (latch_en),
        .clr (clear),
        .d   (stage_q),
        .q   (sel)
    );

endmodule

// File: rtl/swsel_chk.sv
module swsel_chk #(
    parameter int NCH = swsel_pkg::NCH_DEF
) (
    input logic           clk,
    input logic           rst,
    input logic           din,
    input logic           le,
    input logic           clr,
    input logic [NCH-1:0] sel,
    input logic           dout,
    input logic [NCH-1:0] sr
);
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (sr == '0));

    assert_shift_R2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (sr[0] == $past(din)) && (sr[NCH-1:1] == $past(sr[NCH-2:0])));

    assert_follow_R4: assert property (@(posedge clk) disable iff (rst)
        (!le && !clr) |-> (sel == sr));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (le && !clr && $past(le) && !$past(clr)) |-> $stable(sel));

    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        clr |-> (sel == '0));

    assert_tap_R8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (dout == $past(sr[NCH-2])));

endmodule

bind swsel_ctrl swsel_chk #(.NCH(NCH)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .din  (ser_in),
    .le   (latch_en),
    .clr  (clear),
    .sel  (sel),
    .dout (ser_out),
    .sr   (stage_q)
);

// File: tb/sim_swsel_ctrl.sv
`timescale 1ns/1ps
module sim_swsel_ctrl;
    localparam int CLK_PERIOD = 200;
    localparam int N = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic le = 1'b0;
    logic clr = 1'b1;
    logic [N-1:0] sel0, sel1;
    logic dout0, dout1;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [N-1:0] msr0 = '0, msr1 = '0, msel0 = '0, msel1 = '0;
    logic [N-1:0] pre_sel0, pre_sel1;

    always #(CLK_PERIOD/2) clk = ~clk;

    swsel_ctrl #(.NCH(N)) u0 (.clk(clk), .rst(rst), .ser_in(din), .latch_en(le),
        .clear(clr), .sel(sel0), .ser_out(dout0));
    swsel_ctrl #(.NCH(N)) u1 (.clk(clk), .rst(rst), .ser_in(dout0), .latch_en(le),
        .clear(clr), .sel(sel1), .ser_out(dout1));

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    function automatic logic [N-1:0] latch_model(input logic [N-1:0] cur,
            input logic [N-1:0] srv, input logic l, input logic c);
        if (c) return '0;
        if (!l) return srv;
        return cur;
    endfunction

    function automatic string mode_tag(input logic l, input logic c);
        if (c) return "R6";
        if (!l) return "R4";
        return "R5";
    endfunction

    task automatic compare_all(input logic l, input logic c);
        msel0 = latch_model(msel0, msr0, l, c);
        msel1 = latch_model(msel1, msr1, l, c);
        chk(mode_tag(l, c), sel0, msel0);
        chk("R9", sel1, msel1);
        chk("R8", {5'b0, dout0}, {5'b0, msr0[N-1]});
    endtask

    task automatic cycle(input logic d, input logic l, input logic c);
        logic [N-1:0] nxt1;
        @(negedge clk);
        din = d; le = l; clr = c;
        #1;
        compare_all(l, c);
        pre_sel0 = sel0;
        pre_sel1 = sel1;
        @(posedge clk);
        if (rst) begin
            msr0 = '0; msr1 = '0;
        end else begin
            nxt1 = {msr1[N-2:0], msr0[N-1]};
            msr0 = {msr0[N-2:0], d};
            msr1 = nxt1;
        end
        #1;
        compare_all(l, c);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] pat_a, pat_b;
        void'($urandom(32'd4242));
        repeat (3) cycle(1'b1, 1'b0, 1'b1);
        rst = 1'b0;

        // R1: reset left an empty register
        cycle(1'b0, 1'b0, 1'b0);
        chk("R1", sel0, '0);
        chk("R1", {5'b0, dout0}, '0);

        // R2: one bit in, then it advances one stage
        cycle(1'b1, 1'b0, 1'b0);
        chk("R2", sel0, 6'b000001);
        cycle(1'b0, 1'b0, 1'b0);
        chk("R2", sel0, 6'b000010);

        // R5: load with latches held; outputs must not move
        cycle(1'b1, 1'b1, 1'b0);
        cycle(1'b0, 1'b1, 1'b0);
        cycle(1'b1, 1'b1, 1'b0);
        cycle(1'b1, 1'b1, 1'b0);
        cycle(1'b0, 1'b1, 1'b0);
        cycle(1'b0, 1'b1, 1'b0);
        chk("R5", sel0, 6'b000010);
        chk("R8", {5'b0, dout0}, 6'b000001);

        // R3: release, first bit lands on channel 5
        cycle(1'b0, 1'b0, 1'b0);
        chk("R3", pre_sel0, 6'b101100);

        // R6 then R7: clear with latch held, release shows kept contents
        cycle(1'b1, 1'b1, 1'b1);
        chk("R6", pre_sel0, '0);
        cycle(1'b0, 1'b0, 1'b0);
        chk("R7", pre_sel0, 6'b110001);

        // R9: twelve bits through the chain
        pat_a = 6'b110101;
        pat_b = 6'b001110;
        for (int i = N - 1; i >= 0; i--) cycle(pat_a[i], 1'b1, 1'b0);
        for (int i = N - 1; i >= 0; i--) cycle(pat_b[i], 1'b1, 1'b0);
        cycle(1'b0, 1'b0, 1'b0);
        chk("R9", pre_sel1, pat_a);
        chk("R9", pre_sel0, pat_b);

        // Random mix of data, hold and clear
        for (int k = 0; k < 500; k++) begin
            logic rd, rl, rc;
            rd = 1'($urandom);
            rl = ($urandom % 3) == 0;
            rc = ($urandom % 8) == 0;
            cycle(rd, rl, rc);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule